// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides, for one cache-block instruction at a time, whether the instruction may go ahead or must trap. A request carries the current privilege level, whether the hart runs virtualized, the kind of operation (zero, clean/flush or invalidate), three enable vectors taken from the machine-, hypervisor- and supervisor-level environment configuration, and the raw effective address. One clock after the request strobe, the block presents either an "allowed" verdict or an exception with its cause code. In both cases it also presents the address rounded down to the start of its cache block.

The enable checks run in a fixed order. The machine-level check goes first, the virtualized check second and the supervisor-level check last, and the first one that fails sets the cause. The block probes no memory, zeroes nothing and holds no cache state. It hands its verdict and the aligned address to the load/store pipeline.

Top module: `cbo_perm_gate`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `allowed`, `exc_valid`, `exc_cause` and `aligned_addr` are all zero.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. When no request is made, `allowed`, `exc_valid`, `exc_cause` and `aligned_addr` keep their last values.
- R3: At machine privilege (`priv` = 3), a request with a defined operation code is always allowed, whatever the enable vectors hold.
- R4: Below machine privilege, a clear machine-level enable bit for the operation gives cause 2 (illegal instruction). This check wins over every other check, including when virtualization is active.
- R5: With `virt_on` high, privilege at or below supervisor (`priv` ≤ 1), and a clear hypervisor-level enable bit, the result is cause 22 (virtual instruction), provided the machine-level bit is set.
- R6: With `virt_on` high and user privilege (`priv` = 0), a clear supervisor-level enable bit gives cause 22, not cause 2.
- R7: With `virt_on` low, user privilege and a clear supervisor-level bit give cause 2. Supervisor privilege with `virt_on` low ignores the hypervisor and supervisor bits.
- R8: Each operation selects its own bit of every enable vector. Operation code 0 (zero) uses bit 0, code 1 (clean/flush) uses bit 1, and code 2 (invalidate) uses bit 2.
- R9: `aligned_addr` is the request address with its low log2(`BLOCK_BYTES`) bits cleared. The upper bits are unchanged.
- R10: Whenever `rsp_valid` is high, exactly one of `allowed` and `exc_valid` is high. `exc_cause` is 0 when the request is allowed, and otherwise it is 2 or 22.
- R11: Operation code 3 is undefined. It gives cause 2 at every privilege level, machine included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per instruction |
| priv | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| virt_on | input | 1 | Virtualization active |
| op | input | 2 | Operation: 0 zero, 1 clean/flush, 2 invalidate, 3 undefined |
| m_en | input | 3 | Machine-level enables, one bit per operation |
| h_en | input | 3 | Hypervisor-level enables, one bit per operation |
| s_en | input | 3 | Supervisor-level enables, one bit per operation |
| addr | input | ADDR_W | Raw effective address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| allowed | output | 1 | Instruction may proceed |
| exc_valid | output | 1 | Instruction traps |
| exc_cause | output | 5 | Trap cause: 2 illegal instruction, 22 virtual instruction |
| aligned_addr | output | ADDR_W | Address rounded down to the cache block |

## Verification
The assertions assume the following about the inputs:
- `BLOCK_BYTES` is a power of two.
- Every input is stable across the sampling edge.
- `req_valid` is a plain per-cycle strobe with no handshake.

The assertions do not rely on any particular `priv` encoding. Privilege code 2 is simply compared numerically like the other codes.

The stimulus drives inputs only on falling edges and keeps the enable vectors three bits wide. It sends directed requests for each stage of the check order. It then sends a long run of random requests, mixed with idle cycles, that covers every privilege code, the undefined operation and arbitrary addresses.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;

  localparam int N_OPS   = 3;
  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    VERDICT_OK      = 2'd0,
    VERDICT_ILLEGAL = 2'd1,
    VERDICT_VIRT    = 2'd2
  } verdict_e;

endpackage

// File: rtl/cbo_block_align.sv
module cbo_block_align #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);

  generate
    if (OFF_W == 0) begin : g_byte_block
      assign addr_o = addr_i;
    end else begin : g_mask_block
      assign addr_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/cbo_enable_select.sv
module cbo_enable_select
  import cbo_perm_pkg::*;
(
  input  logic [1:0]       op_i,
  input  logic [N_OPS-1:0] m_en_i,
  input  logic [N_OPS-1:0] h_en_i,
  input  logic [N_OPS-1:0] s_en_i,
  output logic             m_bit_o,
  output logic             h_bit_o,
  output logic             s_bit_o,
  output logic             op_known_o
);

  logic [N_OPS-1:0] op_hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_OPS; gi++) begin : g_decode
      assign op_hit[gi] = (op_i == gi[1:0]);
    end
  endgenerate

  assign op_known_o = |op_hit;
  assign m_bit_o    = |(m_en_i & op_hit);
  assign h_bit_o    = |(h_en_i & op_hit);
  assign s_bit_o    = |(s_en_i & op_hit);

endmodule

// File: rtl/cbo_trap_arbiter.sv
module cbo_trap_arbiter
  import cbo_perm_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       op_known_i,
  input  logic       m_bit_i,
  input  logic       h_bit_i,
  input  logic       s_bit_i,
  output verdict_e   verdict_o
);

  logic below_mach;
  logic at_or_below_super;
  logic below_super;
  logic mach_block;
  logic virt_block;
  logic super_block;

  always_comb begin
    below_mach        = (priv_i != PRIV_MACH);
    at_or_below_super = (priv_i <= PRIV_SUPER);
    below_super       = (priv_i == PRIV_USER);

    mach_block  = below_mach && !m_bit_i;
    virt_block  = virt_i && ((at_or_below_super && !h_bit_i) ||
                             (below_super && !s_bit_i));
    super_block = below_super && !s_bit_i;

    // Fixed order: undefined op, machine, virtualized, supervisor.
    if (!op_known_i) begin
      verdict_o = VERDICT_ILLEGAL;
    end else if (mach_block) begin
      verdict_o = VERDICT_ILLEGAL;
    end else if (virt_block) begin
      verdict_o = VERDICT_VIRT;
    end else if (super_block) begin
      verdict_o = VERDICT_ILLEGAL;
    end else begin
      verdict_o = VERDICT_OK;
    end
  end

endmodule

// File: rtl/cbo_perm_gate.sv
module cbo_perm_gate
  import cbo_perm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        priv,
  input  logic              virt_on,
  input  logic [1:0]        op,
  input  logic [2:0]        m_en,
  input  logic [2:0]        h_en,
  input  logic [2:0]        s_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              rsp_valid,
  output logic              allowed,
  output logic              exc_valid,
  output logic [4:0]        exc_cause,
  output logic [ADDR_W-1:0] aligned_addr
);

  logic              m_bit;
  logic              h_bit;
  logic              s_bit;
  logic              op_known;
  verdict_e          verdict;
  logic [ADDR_W-1:0] addr_blk;

  logic               allowed_d;
  logic               exc_valid_d;
  logic [CAUSE_W-1:0] cause_d;
  logic               load_en;

  logic               rsp_valid_q;
  logic               allowed_q;
  logic               exc_valid_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [ADDR_W-1:0]  addr_q;

  cbo_enable_select u_sel (
    .op_i       (op),
    .m_en_i     (m_en),
    .h_en_i     (h_en),
    .s_en_i     (s_en),
    .m_bit_o    (m_bit),
    .h_bit_o    (h_bit),
    .s_bit_o    (s_bit),
    .op_known_o (op_known)
  );

  cbo_trap_arbiter u_arb (
    .priv_i     (priv),
    .virt_i     (virt_on),
    .op_known_i (op_known),
    .m_bit_i    (m_bit),
    .h_bit_i    (h_bit),
    .s_bit_i    (s_bit),
    .verdict_o  (verdict)
  );

  cbo_block_align #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_align (
    .addr_i (addr),
    .addr_o (addr_blk)
  );

  always_comb begin
    load_en     = req_valid;
    allowed_d   = 1'b0;
    exc_valid_d = 1'b0;
    cause_d     = CAUSE_NONE;
    unique case (verdict)
      VERDICT_OK:      allowed_d = 1'b1;
      VERDICT_ILLEGAL: begin exc_valid_d = 1'b1; cause_d = CAUSE_ILLEGAL; end
      VERDICT_VIRT:    begin exc_valid_d = 1'b1; cause_d = CAUSE_VIRT;    end
      default:         begin exc_valid_d = 1'b1; cause_d = CAUSE_ILLEGAL; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      allowed_q   <= 1'b0;
      exc_valid_q <= 1'b0;
      cause_q     <= CAUSE_NONE;
      addr_q      <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      if (load_en) begin
        allowed_q   <= allowed_d;
        exc_valid_q <= exc_valid_d;
        cause_q     <= cause_d;
        addr_q      <= addr_blk;
      end
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign allowed      = allowed_q;
  assign exc_valid    = exc_valid_q;
  assign exc_cause    = cause_q;
  assign aligned_addr = addr_q;

endmodule

// File: rtl/cbo_perm_gate_chk.sv
module cbo_perm_gate_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        priv,
  input logic [1:0]        op,
  input logic              rsp_valid,
  input logic              allowed,
  input logic              exc_valid,
  input logic [4:0]        exc_cause,
  input logic [ADDR_W-1:0] aligned_addr
);

  localparam int OFF_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BLOCK_BYTES - 1);

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(aligned_addr) && $stable(exc_cause) &&
                    $stable(allowed) && $stable(exc_valid)));

  a_r3_machine_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv == 2'd3 && op != 2'd3) |=> allowed);

  a_r9_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((aligned_addr & LOW_MASK) == '0));

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({allowed, exc_valid}));

  a_r10_cause_values: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (allowed ? (exc_cause == 5'd0)
                           : (exc_cause == 5'd2 || exc_cause == 5'd22)));

  a_r11_undefined_op: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == 2'd3) |=> (exc_valid && exc_cause == 5'd2));

  initial begin
    a_r9_param_shape: assert (OFF_W >= 1 && (BLOCK_BYTES & (BLOCK_BYTES - 1)) == 0);
  end

endmodule

bind cbo_perm_gate cbo_perm_gate_chk #(
  .ADDR_W      (ADDR_W),
  .BLOCK_BYTES (BLOCK_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .priv         (priv),
  .op           (op),
  .rsp_valid    (rsp_valid),
  .allowed      (allowed),
  .exc_valid    (exc_valid),
  .exc_cause    (exc_cause),
  .aligned_addr (aligned_addr)
);

// File: tb/test_cbo_perm_gate.sv
`timescale 1ns/1ps
module test_cbo_perm_gate;

  localparam int AW    = 32;
  localparam int BLK   = 64;
  localparam int TCLK  = 4;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    priv;
  logic          virt_on;
  logic [1:0]    op;
  logic [2:0]    m_en, h_en, s_en;
  logic [AW-1:0] addr;
  logic          rsp_valid, allowed, exc_valid;
  logic [4:0]    exc_cause;
  logic [AW-1:0] aligned_addr;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 0;
  string cur_tag  = "R1";

  logic          e_rsp, e_ok, e_exc;
  logic [4:0]    e_cause;
  logic [AW-1:0] e_addr;

  cbo_perm_gate #(.ADDR_W(AW), .BLOCK_BYTES(BLK)) i_cbo_perm_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .priv(priv),
    .virt_on(virt_on), .op(op), .m_en(m_en), .h_en(h_en), .s_en(s_en),
    .addr(addr), .rsp_valid(rsp_valid), .allowed(allowed),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .aligned_addr(aligned_addr)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  // Behavioural reference: returns cause, 0 meaning allowed.
  function automatic int ref_cause(int p, bit v, int o, int m, int h, int s);
    int mb, hb, sb;
    if (o == 3) return 2;                                  // R11
    mb = (m >> o) & 1; hb = (h >> o) & 1; sb = (s >> o) & 1; // R8
    if (p == 3) return 0;                                  // R3
    if (mb == 0) return 2;                                 // R4
    if (v && ((p <= 1 && hb == 0) || (p < 1 && sb == 0))) return 22; // R5 R6
    if (p < 1 && sb == 0) return 2;                        // R7
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_rsp <= 0; e_ok <= 0; e_exc <= 0; e_cause <= 0; e_addr <= 0;
    end else begin
      e_rsp <= req_valid;
      if (req_valid) begin
        int c;
        c = ref_cause(int'(priv), virt_on, int'(op), int'(m_en), int'(h_en), int'(s_en));
        e_ok    <= (c == 0);
        e_exc   <= (c != 0);
        e_cause <= 5'(c);
        e_addr  <= addr - (addr % BLK);                    // R9
      end
    end
  end

  task automatic cmp(string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      cmp("rsp_valid", AW'(rsp_valid), AW'(e_rsp));
      cmp("allowed",   AW'(allowed),   AW'(e_ok));
      cmp("exc_valid", AW'(exc_valid), AW'(e_exc));
      cmp("exc_cause", AW'(exc_cause), AW'(e_cause));
      cmp("aligned_addr", aligned_addr, e_addr);
    end
  end

  task automatic req(string tag, int p, bit v, int o, int m, int h, int s, logic [AW-1:0] a);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; priv = 2'(p); virt_on = v; op = 2'(o);
    m_en = 3'(m); h_en = 3'(h); s_en = 3'(s); addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag = "R2";
      req_valid = 0; addr = $urandom; op = 2'($urandom); priv = 2'($urandom);
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; priv = 0; virt_on = 0; op = 0;
    m_en = 0; h_en = 0; s_en = 0; addr = 0;
    cur_tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(2);
    // R3: machine mode ignores all enables
    for (int o = 0; o < 3; o++) req("R3", 3, 1, o, 0, 0, 0, 32'h1234_5678);
    // R4: machine bit wins even when virtualized
    req("R4", 1, 1, 0, 0, 0, 0, 32'h0000_1000);
    req("R4", 0, 1, 1, 5, 0, 0, 32'h0000_2000);
    // R5: hypervisor bit clear under virtualization
    req("R5", 1, 1, 0, 7, 0, 7, 32'h0000_0040);
    req("R5", 0, 1, 2, 7, 0, 7, 32'h0000_0080);
    // R6: supervisor bit clear in virtualized user mode
    req("R6", 0, 1, 1, 7, 7, 0, 32'h0000_00C0);
    req("R6", 1, 1, 1, 7, 7, 0, 32'h0000_0100);
    // R7: non-virtualized
    req("R7", 0, 0, 0, 7, 7, 0, 32'h0000_0140);
    req("R7", 1, 0, 0, 7, 0, 0, 32'h0000_0180);
    req("R7", 0, 0, 2, 7, 0, 7, 32'h0000_01C0);
    // R8: each op reads its own bit
    req("R8", 1, 0, 0, 6, 7, 7, 32'h0);
    req("R8", 1, 0, 1, 5, 7, 7, 32'h0);
    req("R8", 1, 0, 2, 3, 7, 7, 32'h0);
    req("R8", 1, 0, 1, 2, 0, 0, 32'h0);
    req("R8", 0, 1, 2, 4, 4, 4, 32'h0);
    // R9: alignment corners
    req("R9", 3, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
    req("R9", 3, 0, 0, 0, 0, 0, 32'h0000_003F);
    req("R9", 3, 0, 0, 0, 0, 0, 32'h0000_0040);
    // R11: undefined op at every privilege
    for (int p = 0; p < 4; p++) req("R11", p, 0, 3, 7, 7, 7, 32'hABCD_EF01);
    // R2: back-to-back then idle hold
    req("R2", 0, 1, 0, 7, 7, 7, 32'h5555_5555);
    idle(3);
    // R10: random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      req("R10", $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3),
          $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), $urandom);
    end
    idle(2);
    // R1: reset mid-run clears outputs
    @(negedge clk);
    cur_tag = "R1";
    rst_n = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(TCLK * 150000);
    if (!done) begin
      done = 1;
      n_fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule